// File: doc/BRIEF.md
# Combinational ALU with Status Flags

This block is a stateless arithmetic-logic unit for a datapath. Two operands of a configurable width enter together with an operation code. The block returns one result word and four condition bits: zero, carry, negative and signed overflow. It holds no clock and no storage. Every output is a function of the inputs present at that moment. Latching the flags and sequencing the operations are left to the surrounding datapath.

Inside, the adder/subtractor and the bitwise units all evaluate every operand pair at the same time. A selector then picks one of their results. Addition and subtraction share a single ripple chain. One subtract line inverts every bit of the second operand and also forms the chain's carry-in, so a subtract takes the same path and the same delay as an add. A build option adds an exclusive-OR operation, which widens the operation code from two to three bits.

Top module: `alu_core`

## Requirements
- R1: Op code 0 (binary 00/000) returns the sum of `a_i` and `b_i` modulo 2^W.
- R2: Op code 1 (binary 01/001) returns `a_i` minus `b_i` modulo 2^W. It is computed as `a_i` + NOT `b_i` + 1 in the same adder that performs the add.
- R3: For op codes 0 and 1, `carry_o` is the raw carry out of the most significant adder stage. After a subtract, 1 means `a_i >= b_i` unsigned (no borrow), and the flag is not inverted.
- R4: For op codes 0 and 1, `ovf_o` is 1 exactly when the signed (two's-complement) result does not fit in W bits. This equals the carry into the sign stage XOR the carry out of it.
- R5: `zero_o` is 1 exactly when every bit of `res_o` is 0, for every op code.
- R6: `neg_o` equals bit W-1 of `res_o`, for every op code.
- R7: Op code 2 (10/010) returns the bitwise AND and op code 3 (11/011) returns the bitwise OR. With `EN_XOR=1`, op code 4 (100) returns the bitwise XOR. For all of these, `carry_o` and `ovf_o` are 0.
- R8: With `EN_XOR=1`, op codes 5 to 7 return a result of 0, with `zero_o`=1 and `carry_o`, `neg_o` and `ovf_o` all 0.
- R9: The outputs follow the inputs with no clock: a new input value appears at the outputs within the same time step, whatever the input history.
- R10: At W=4, 1000+1000 gives 0000 with Z=1, C=1, V=1, N=0. Subtracting any operand from itself gives 0 with Z=1, C=1, N=0, V=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand |
| b_i | input | W | Second operand (the subtrahend) |
| op_i | input | 2, or 3 when EN_XOR=1 | Operation code |
| res_o | output | W | Selected result |
| zero_o | output | 1 | All result bits are clear |
| carry_o | output | 1 | Carry out of the top stage (arithmetic only) |
| neg_o | output | 1 | Result sign bit |
| ovf_o | output | 1 | Signed overflow (arithmetic only) |

## Verification
The bench sweeps all 256 operand pairs at W=4 for each of the eight op codes. A bench model built on wider integer arithmetic computes the expected outputs independently of the adder chain. In the add and subtract sweeps, the pairs of same-sign operands are the ones that separate a true carry-into-versus-carry-out overflow from a sign-only check. The subtract pairs also tell a raw carry apart from an inverted borrow. The logic sweeps show that carry and overflow stay clear even where the adder itself would carry. The edge cases are checked on their own: two most-negative operands, operands equal to each other, and zero plus zero. Reversing the order of the sweep checks that no history reaches the outputs.

// File: rtl/alu_pkg.sv
package alu_pkg;
   localparam int unsigned CODE_W = 3;
   localparam logic [CODE_W-1:0] OP_ADD = 3'd0;
   localparam logic [CODE_W-1:0] OP_SUB = 3'd1;
   localparam logic [CODE_W-1:0] OP_AND = 3'd2;
   localparam logic [CODE_W-1:0] OP_OR  = 3'd3;
   localparam logic [CODE_W-1:0] OP_XOR = 3'd4;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   input  logic         sub_i,
   output logic [W-1:0] sum_o,
   output logic         c_top_in_o,
   output logic         c_out_o
);
   logic [W:0]   chain;
   logic [W-1:0] y_eff;

   assign y_eff    = y_i ^ {W{sub_i}};
   assign chain[0] = sub_i;

   for (genvar i = 0; i < W; i++) begin : g_stage
      assign sum_o[i]   = x_i[i] ^ y_eff[i] ^ chain[i];
      assign chain[i+1] = (x_i[i] & y_eff[i]) | (x_i[i] & chain[i]) | (y_eff[i] & chain[i]);
   end

   assign c_top_in_o = chain[W-1];
   assign c_out_o    = chain[W];
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
   parameter int unsigned W       = 4,
   parameter bit          EN_XOR  = 1'b0
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   output logic [W-1:0] and_o,
   output logic [W-1:0] or_o,
   output logic [W-1:0] xor_o
);
   assign and_o = x_i & y_i;
   assign or_o  = x_i | y_i;

   if (EN_XOR) begin : g_xor
      assign xor_o = x_i ^ y_i;
   end else begin : g_no_xor
      assign xor_o = '0;
   end
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] res_i,
   input  logic         arith_i,
   input  logic         c_top_in_i,
   input  logic         c_out_i,
   output logic         zero_o,
   output logic         carry_o,
   output logic         neg_o,
   output logic         ovf_o
);
   assign zero_o  = ~(|res_i);
   assign neg_o   = res_i[W-1];
   assign carry_o = arith_i & c_out_i;
   assign ovf_o   = arith_i & (c_top_in_i ^ c_out_i);
endmodule

// File: rtl/alu_core.sv
module alu_core
   import alu_pkg::*;
#(
   parameter int unsigned W      = 4,
   parameter bit          EN_XOR = 1'b0
) (
   input  logic [W-1:0]                a_i,
   input  logic [W-1:0]                b_i,
   input  logic [(EN_XOR ? 3 : 2)-1:0] op_i,
   output logic [W-1:0]                res_o,
   output logic                        zero_o,
   output logic                        carry_o,
   output logic                        neg_o,
   output logic                        ovf_o
);
   localparam int unsigned SEL_W = EN_XOR ? 3 : 2;

   if (W < 2) begin : g_bad_width
      $error("alu_core: W must be at least 2");
   end
   if (SEL_W > CODE_W) begin : g_bad_sel
      $error("alu_core: select wider than code space");
   end

   logic [CODE_W-1:0] op_full;
   logic              is_sub, is_arith;
   logic [W-1:0]      sum_w, and_w, or_w, xor_w;
   logic              c_top_in, c_out;

   assign op_full  = CODE_W'(op_i);
   assign is_sub   = (op_full == OP_SUB);
   assign is_arith = (op_full == OP_ADD) || (op_full == OP_SUB);

   alu_addsub #(.W(W)) u_addsub (
      .x_i(a_i), .y_i(b_i), .sub_i(is_sub),
      .sum_o(sum_w), .c_top_in_o(c_top_in), .c_out_o(c_out)
   );

   alu_logic #(.W(W), .EN_XOR(EN_XOR)) u_logic (
      .x_i(a_i), .y_i(b_i), .and_o(and_w), .or_o(or_w), .xor_o(xor_w)
   );

   always_comb begin
      unique case (op_full)
         OP_ADD, OP_SUB: res_o = sum_w;
         OP_AND:         res_o = and_w;
         OP_OR:          res_o = or_w;
         OP_XOR:         res_o = xor_w;
         default:        res_o = '0;
      endcase
   end

   alu_flags #(.W(W)) u_flags (
      .res_i(res_o), .arith_i(is_arith), .c_top_in_i(c_top_in), .c_out_i(c_out),
      .zero_o(zero_o), .carry_o(carry_o), .neg_o(neg_o), .ovf_o(ovf_o)
   );

   logic [W:0] ref_wide;
   assign ref_wide = {1'b0, a_i} + {1'b0, b_i};

   always_comb begin
      a_r3_add_carry: assert (!(op_full == OP_ADD) || (carry_o == ref_wide[W]))
         else $error("R3 add carry mismatch");
      a_r4_overflow_signs: assert (!(op_full == OP_ADD && ovf_o)
            || (a_i[W-1] == b_i[W-1] && res_o[W-1] != a_i[W-1]))
         else $error("R4 overflow without sign conflict");
      a_r10_self_sub: assert (!(is_sub && a_i == b_i)
            || (zero_o && carry_o && !neg_o && !ovf_o))
         else $error("R10 equal subtract flags");
      a_r7_logic_cv: assert (is_arith || (!carry_o && !ovf_o))
         else $error("R7 carry/overflow on logic op");
      a_r5_zero_result: assert (zero_o == (res_o == '0))
         else $error("R5 zero flag mismatch");
   end
endmodule

// File: tb/sim_alu_core.sv
module sim_alu_core;
   localparam int W = 4;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic [W-1:0] a, b, res;
   logic [2:0]   op;
   logic         z, c, n, v;
   int checks = 0;
   int errors = 0;

   alu_core #(.W(W), .EN_XOR(1'b1)) u0 (
      .a_i(a), .b_i(b), .op_i(op), .res_o(res),
      .zero_o(z), .carry_o(c), .neg_o(n), .ovf_o(v)
   );

   function automatic int sgn(input int x);
      return (x >= 8) ? x - 16 : x;
   endfunction

   task automatic check(input string req, input int got, input int exp, input string what);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s a=%0d b=%0d op=%0d got=%0d exp=%0d", req, what, a, b, op, got, exp);
      end
   endtask

   task automatic apply_and_check(input int ai, input int bi, input int oi);
      int s, er, ec, ev, sd;
      @(negedge clk);
      a = ai[W-1:0]; b = bi[W-1:0]; op = oi[2:0];
      #1;
      ec = 0; ev = 0;
      case (oi)
         0: begin s = ai + bi; er = s & 15; ec = s >> 4; sd = sgn(ai) + sgn(bi); ev = (sd > 7 || sd < -8) ? 1 : 0; end
         1: begin s = ai + ((~bi) & 15) + 1; er = s & 15; ec = s >> 4; sd = sgn(ai) - sgn(bi); ev = (sd > 7 || sd < -8) ? 1 : 0; end
         2: er = ai & bi;
         3: er = ai | bi;
         4: er = ai ^ bi;
         default: er = 0;
      endcase
      if (oi == 0) check("R1", res, er, "add result");
      else if (oi == 1) check("R2", res, er, "sub result");
      else if (oi <= 4) check("R7", res, er, "logic result");
      else check("R8", res, er, "unused code result");
      check("R3", c, ec, "carry");
      check("R4", v, ev, "overflow");
      check("R5", z, (er == 0) ? 1 : 0, "zero");
      check("R6", n, (er >> 3) & 1, "negative");
   endtask

   task automatic t_reset_state();
      apply_and_check(0, 0, 0);
      check("R10", z, 1, "0+0 only zero set");
   endtask

   task automatic t_sweep_forward();
      for (int o = 0; o < 8; o++)
         for (int x = 0; x < 16; x++)
            for (int y = 0; y < 16; y++)
               apply_and_check(x, y, o);
   endtask

   task automatic t_history_free();
      // R9: reversed order, no history may influence outputs
      for (int o = 1; o >= 0; o--)
         for (int x = 15; x >= 0; x -= 5)
            apply_and_check(x, 15 - x, o);
   endtask

   task automatic t_corners();
      apply_and_check(8, 8, 0);
      check("R10", {res, z, c, v, n}, {4'b0000, 1'b1, 1'b1, 1'b1, 1'b0}, "8+8 flags");
      for (int x = 0; x < 16; x++) begin
         apply_and_check(x, x, 1);
         check("R10", {res, z, c, n, v}, {4'b0000, 1'b1, 1'b1, 1'b0, 1'b0}, "x-x flags");
      end
      apply_and_check(15, 15, 2);
      check("R7", {c, v}, 0, "AND no carry");
      apply_and_check(7, 0, 5);
      check("R8", {res, z, c, n, v}, {4'b0000, 1'b1, 3'b000}, "code 5");
   endtask

   initial begin
      a = '0; b = '0; op = '0;
      t_reset_state();
      t_sweep_forward();
      t_history_free();
      t_corners();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL R9 watchdog expired got=1 exp=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule